// File: doc/BRIEF.md
# Interrupt Event Latch Reporter

This block sits between a system interrupt request line, a vector of general-purpose I/O pins and the polling logic of a USB interrupt endpoint. When the interrupt line is seen high and no earlier report is waiting, the block stores the pin levels and raises a single pending flag. Each poll of the endpoint is answered with either the stored pin snapshot or a NAK. Delivering a snapshot clears the flag, so each interrupt event gives exactly one report.

The endpoint logic pulses the poll strobe for one cycle. One clock later, the block presents a response code and the response data for exactly one cycle. The endpoint logic then turns that response into a DATA packet or a NAK handshake. Packet framing, CRC and transfer sequencing belong to the endpoint logic, not to this block.

Top module: `irq_snap_reporter`

## Requirements
- R1: While the pending flag is clear and the interrupt request input is high at a rising clock edge, that edge stores the GPIO input levels and sets the pending flag.
- R2: While the pending flag is set, the stored snapshot does not change, whatever the GPIO pins or the interrupt request do. A later poll returns the value stored when the flag was set.
- R3: A poll while the pending flag is set is answered with code 2'b10 (DATA), with the stored snapshot on the data output. The same edge clears the pending flag, so the next poll with the interrupt request low gets a NAK.
- R4: A poll while the pending flag is clear is answered with code 2'b01 (NAK). This holds even if the interrupt request is high in the same cycle. In that case the same edge still takes the snapshot, and the next poll returns it.
- R5: The response appears on the cycle after the one-cycle poll strobe. The valid output is high for exactly that cycle. In every other cycle the code is 2'b00 (idle).
- R6: If the interrupt request is still high after a read clears the flag, the next clock edge takes a new snapshot of the pins.
- R7: With the default zero-fill option, the data output is all zeros in every cycle whose code is not DATA.
- R8: A synchronous active-low reset clears the pending flag, the snapshot and all response outputs. After reset, a poll gets a NAK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req_i | input | 1 | System interrupt request level |
| gpio_i | input | GPIO_W | General-purpose pin levels |
| poll_i | input | 1 | One-cycle interrupt endpoint poll strobe |
| rsp_valid_o | output | 1 | Response valid, the cycle after a poll |
| rsp_code_o | output | 2 | 00 idle, 01 NAK, 10 DATA |
| rsp_data_o | output | GPIO_W | Snapshot returned with a DATA response |

## Verification
The assertions check four rules on every cycle. The snapshot stays frozen while a report is pending. A high request with no pending report always sets the flag. A poll always produces a one-cycle response whose code matches the flag as it stood at the poll. A DATA response carries the snapshot held at the poll.

Some behaviour only the directed scenarios can show. These are the order of events across several cycles: one event giving exactly one report, a request arriving in the same cycle as a poll, re-arming while the request stays high, and a reset clearing a pending report. They also cover the actual pin values in the reports, measured against values chosen in the bench.

// File: rtl/irq_snap_pkg.sv
package irq_snap_pkg;
   typedef enum logic [1:0] {
      RSP_IDLE = 2'b00,
      RSP_NAK  = 2'b01,
      RSP_DATA = 2'b10
   } rsp_code_e;
endpackage

// File: rtl/irq_snap_latch.sv
module irq_snap_latch #(
   parameter int GPIO_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_i,
   input  logic [GPIO_W-1:0] gpio_i,
   input  logic              rd_i,
   output logic              pend_o,
   output logic [GPIO_W-1:0] snap_o
);
   logic              pend_q;
   logic [GPIO_W-1:0] snap_q;
   logic              take;

   assign take = irq_i & ~pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         snap_q <= '0;
      end else if (take) begin
         snap_q <= gpio_i;
         pend_q <= 1'b1;
      end else if (rd_i && pend_q) begin
         pend_q <= 1'b0;
      end
   end

   assign pend_o = pend_q;
   assign snap_o = snap_q;

   // R2
   snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |=> $stable(snap_q));
   // R1
   capture_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pend_q && irq_i) |=> pend_q);
   // R3
   read_clears_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && rd_i) |=> !pend_q);
endmodule

// File: rtl/irq_snap_resp.sv
module irq_snap_resp
   import irq_snap_pkg::*;
#(
   parameter int GPIO_W         = 8,
   parameter bit ZERO_IDLE_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              poll_i,
   input  logic              pend_i,
   input  logic [GPIO_W-1:0] snap_i,
   output logic              valid_o,
   output rsp_code_e         code_o,
   output logic [GPIO_W-1:0] data_o
);
   rsp_code_e         code_d;
   logic              give;
   logic [GPIO_W-1:0] data_q;

   assign give = poll_i & pend_i;

   always_comb begin
      if (!poll_i)     code_d = RSP_IDLE;
      else if (pend_i) code_d = RSP_DATA;
      else             code_d = RSP_NAK;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_o <= 1'b0;
         code_o  <= RSP_IDLE;
      end else begin
         valid_o <= poll_i;
         code_o  <= code_d;
      end
   end

   generate
      if (ZERO_IDLE_DATA) begin : g_zero_fill
         always_ff @(posedge clk) begin
            if (!rst_n)    data_q <= '0;
            else if (give) data_q <= snap_i;
            else           data_q <= '0;
         end
      end else begin : g_hold_last
         always_ff @(posedge clk) begin
            if (!rst_n)    data_q <= '0;
            else if (give) data_q <= snap_i;
         end
      end
   endgenerate

   assign data_o = data_q;

   // R5
   poll_gives_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_i |=> valid_o);
   // R5
   idle_without_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !poll_i |=> (code_o == RSP_IDLE && !valid_o));
   // R5
   code_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(code_o));
endmodule

// File: rtl/irq_snap_reporter.sv
module irq_snap_reporter
   import irq_snap_pkg::*;
#(
   parameter int GPIO_W         = 8,
   parameter bit ZERO_IDLE_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_req_i,
   input  logic [GPIO_W-1:0] gpio_i,
   input  logic              poll_i,
   output logic              rsp_valid_o,
   output logic [1:0]        rsp_code_o,
   output logic [GPIO_W-1:0] rsp_data_o
);
   generate
      if (GPIO_W < 1 || GPIO_W > 1024) begin : g_bad_width
         $error("irq_snap_reporter: GPIO_W out of range");
      end
   endgenerate

   logic              pend;
   logic [GPIO_W-1:0] snap;
   rsp_code_e         code;

   irq_snap_latch #(.GPIO_W(GPIO_W)) u_latch (
      .clk    (clk),
      .rst_n  (rst_n),
      .irq_i  (irq_req_i),
      .gpio_i (gpio_i),
      .rd_i   (poll_i),
      .pend_o (pend),
      .snap_o (snap)
   );

   irq_snap_resp #(.GPIO_W(GPIO_W), .ZERO_IDLE_DATA(ZERO_IDLE_DATA)) u_resp (
      .clk     (clk),
      .rst_n   (rst_n),
      .poll_i  (poll_i),
      .pend_i  (pend),
      .snap_i  (snap),
      .valid_o (rsp_valid_o),
      .code_o  (code),
      .data_o  (rsp_data_o)
   );

   assign rsp_code_o = code;

   // R3
   data_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_i && pend) |=> (rsp_code_o == 2'b10 && rsp_data_o == $past(snap)));
   // R4
   nak_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (poll_i && !pend) |=> rsp_code_o == 2'b01);
endmodule

// File: tb/test_irq_snap_reporter.sv
module test_irq_snap_reporter;
   localparam int CLK_P = 10;
   localparam int W     = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         irq = 1'b0;
   logic [W-1:0] gpio = '0;
   logic         poll = 1'b0;
   logic         rsp_valid;
   logic [1:0]   rsp_code;
   logic [W-1:0] rsp_data;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_P/2) clk = ~clk;

   irq_snap_reporter #(.GPIO_W(W)) i_irq_snap_reporter (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_req_i   (irq),
      .gpio_i      (gpio),
      .poll_i      (poll),
      .rsp_valid_o (rsp_valid),
      .rsp_code_o  (rsp_code),
      .rsp_data_o  (rsp_data)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic do_poll();
      poll = 1'b1;
      tick();
      poll = 1'b0;
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      tick(); tick();
      chk("R8 valid in reset", rsp_valid, 0);
      chk("R8 code in reset", rsp_code, 2'b00);
      chk("R8 data in reset", rsp_data, 0);
      rst_n = 1'b1;
      tick();
   endtask

   task automatic t_idle_nak();
      irq = 0;
      do_poll();
      chk("R4 NAK without pending", rsp_code, 2'b01);
      chk("R5 valid after poll", rsp_valid, 1);
      chk("R7 zero data on NAK", rsp_data, 0);
      tick();
      chk("R5 valid one cycle only", rsp_valid, 0);
      chk("R5 idle code", rsp_code, 2'b00);
   endtask

   task automatic t_capture();
      gpio = 8'hA5; irq = 1;
      tick();
      irq = 0; gpio = 8'h3C;
      tick();
      chk("R7 zero data while idle", rsp_data, 0);
      do_poll();
      chk("R1 DATA code", rsp_code, 2'b10);
      chk("R3 snapshot data", rsp_data, 8'hA5);
      tick();
      do_poll();
      chk("R3 flag cleared gives NAK", rsp_code, 2'b01);
   endtask

   task automatic t_hold();
      gpio = 8'h11; irq = 1;
      tick();
      irq = 0; gpio = 8'hFF;
      tick();
      gpio = 8'h22; irq = 1;
      tick();
      irq = 0;
      tick();
      do_poll();
      chk("R2 held code", rsp_code, 2'b10);
      chk("R2 held snapshot", rsp_data, 8'h11);
      tick();
      do_poll();
      chk("R2 second irq while pending ignored", rsp_code, 2'b01);
   endtask

   task automatic t_rearm();
      gpio = 8'h40; irq = 1;
      tick();
      gpio = 8'h41;
      do_poll();
      chk("R6 first report", rsp_data, 8'h40);
      gpio = 8'h42;
      tick();
      irq = 0; gpio = 8'h00;
      tick();
      do_poll();
      chk("R6 rearm code", rsp_code, 2'b10);
      chk("R6 rearm snapshot", rsp_data, 8'h42);
   endtask

   task automatic t_same_cycle();
      tick();
      gpio = 8'h77; irq = 1;
      do_poll();
      irq = 0; gpio = 8'h00;
      chk("R4 NAK when irq with poll", rsp_code, 2'b01);
      tick();
      do_poll();
      chk("R4 snapshot from poll cycle", rsp_data, 8'h77);
      chk("R4 DATA on next poll", rsp_code, 2'b10);
   endtask

   task automatic t_reset_clear();
      tick();
      gpio = 8'h5A; irq = 1;
      tick();
      irq = 0;
      rst_n = 0;
      tick();
      rst_n = 1;
      tick();
      do_poll();
      chk("R8 reset drops pending", rsp_code, 2'b01);
      chk("R8 reset zero data", rsp_data, 0);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_idle_nak();
            t_capture();
            t_hold();
            t_rearm();
            t_same_cycle();
            t_reset_clear();
         end
         begin
            repeat (5000) @(posedge clk);
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule